// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs one serial-flash transaction each time software asks for one. Software works through a small byte-wide register window. It sets a command byte and a packed count register that holds how many bytes to send and how many to receive. It loads the bytes to send into an eight-entry byte FIFO through a single data port, then writes a start bit. The engine drops chip select and sends the command byte. It then sends the loaded bytes from the FIFO and clocks the requested number of reply bytes back into the same FIFO, placed after the sent bytes. Finally it raises chip select and holds a short idle gap before it reports completion.

Software reads results by clearing the FIFO pointer and reading the data port repeatedly. The first entries it reads are the bytes it sent, and the replies follow. The serial link runs in mode 0: the clock idles low, data changes on the falling edge, it is sampled on the rising edge, and the most significant bit comes first. Each half period of the serial clock lasts `DIV` system clocks.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset every readable register (offsets 0x0, 0x1, 0x2, 0x3, 0xD) reads 0, chip select (`cs_n`) is high, and `sck` and `mosi` are low.
- R2: The byte written at offset 0x0 reads back at offset 0x0. It is the first byte shifted out after chip select falls, most significant bit first.
- R3: Writing 1 to bit 0 of offset 0x2 starts a transaction. While the transaction runs, bit 0 of offset 0x2 and bit 7 of offset 0x3 both read 1. Both read 0 once it has finished.
- R4: Writing 1 to bit 4 of offset 0x2 sets the FIFO pointer to 0. The pointer reads back in bits 2:0 of offset 0xD. Each write or read of the data port at offset 0xC accesses the entry at the pointer and then advances the pointer by one.
- R5: Offset 0x1 holds the send count in bits 3:0 and the reply count in bits 7:4. After the command byte the engine shifts out that many FIFO entries, starting at entry 0 and in order, most significant bit first. A count of seven is supported.
- R6: Reply bytes are sampled from `miso` on rising `sck` edges, most significant bit first. They are stored in FIFO entries that start just after the last sent entry, so after a pointer clear the first reply is the read that follows the sent bytes.
- R7: With both counts zero, a transaction sends exactly the command byte.
- R8: While a transaction runs, writes to offsets 0x0, 0x1 and 0xC and further start requests have no effect: the registers and the pointer keep their values, and no extra transaction follows.
- R9: The FIFO pointer is three bits wide and wraps modulo 8, so nine data-port writes after a clear leave it at 1.
- R10: Chip select goes low on the clock after the start write. It stays low for exactly 16·DIV·(1+send+reply) clocks. `sck` is low whenever chip select is high, and the engine reports busy for a further 4·DIV clocks after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads of 0xC advance the pointer) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the clock after `rd_en` |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A register read returns its value one clock after the read strobe, so the bench drives the strobe at one falling edge and takes `rdata` at the next. Chip select has an exact schedule: it falls at the first edge after the start write and rises 16·DIV·N edges later. A behavioural model in the bench counts those edges down from its own copy of the counts and compares `cs_n` on every falling clock edge. The model takes no account of start requests made while busy, so any extra transaction shows up as a mismatch. A behavioural flash model captures the bytes on `mosi` and supplies a reply that depends on the byte slot, which gives each reply byte an expected value of its own.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNTS = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_STAT   = 4'h3;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_CLR_BIT = 4;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spif_fifo.sv
module spif_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_clr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [PW-1:0] ptr,
  input  logic [PW-1:0] eng_ridx,
  output logic [W-1:0]  eng_rdata,
  input  logic          eng_wr,
  input  logic [PW-1:0] eng_widx,
  input  logic [W-1:0]  eng_wdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (eng_wr)      mem[eng_widx] <= eng_wdata;
    else if (bus_wr) mem[ptr]      <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || ptr_clr)      ptr <= '0;
    else if (bus_wr || bus_rd) ptr <= ptr + 1'b1;
  end

  assign bus_rdata = mem[ptr];
  assign eng_rdata = mem[eng_ridx];

  a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !ptr_clr && ptr == PW'(DEPTH-1)) |=> (ptr == '0));
endmodule

// File: rtl/spif_shifter.sv
module spif_shifter
  import spif_pkg::*;
#(
  parameter int DIV = 2,
  parameter int PW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [3:0]    tx_cnt,
  input  logic [3:0]    rx_cnt,
  output logic          busy,
  output logic [PW-1:0] fifo_ridx,
  input  logic [7:0]    fifo_rdata,
  output logic          fifo_wr,
  output logic [PW-1:0] fifo_widx,
  output logic [7:0]    fifo_wdata,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int CW = $clog2(4*DIV) + 1;

  eng_state_t   st;
  logic [CW-1:0] div_cnt;
  logic [3:0]   bit_cnt;
  logic [4:0]   byte_idx, total, nxt;
  logic [3:0]   tx_n;
  logic [7:0]   tx_sh, rx_sh;
  logic         tick, byte_end;

  assign tick      = (st == ENG_SHIFT) && (div_cnt == CW'(DIV-1));
  assign byte_end  = tick && sck && (bit_cnt == 4'd8);
  assign nxt       = byte_idx + 5'd1;
  assign fifo_ridx = byte_idx[PW-1:0];
  assign fifo_widx = PW'(byte_idx - 5'd1);
  assign fifo_wr   = byte_end && (byte_idx > {1'b0, tx_n});
  assign fifo_wdata = rx_sh;
  assign busy      = (st != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ENG_IDLE; div_cnt <= '0; bit_cnt <= '0; byte_idx <= '0;
      total <= '0; tx_n <= '0; tx_sh <= '0; rx_sh <= '0;
      sck <= 1'b0; cs_n <= 1'b1; mosi <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: if (start) begin
          st       <= ENG_SHIFT;
          cs_n     <= 1'b0;
          tx_sh    <= opcode;
          mosi     <= opcode[7];
          byte_idx <= '0;
          bit_cnt  <= '0;
          div_cnt  <= '0;
          tx_n     <= tx_cnt;
          total    <= 5'd1 + {1'b0, tx_cnt} + {1'b0, rx_cnt};
        end
        ENG_SHIFT: begin
          if (!tick) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (!sck) begin
              sck     <= 1'b1;
              rx_sh   <= {rx_sh[6:0], miso};
              bit_cnt <= bit_cnt + 4'd1;
            end else begin
              sck <= 1'b0;
              if (bit_cnt == 4'd8) begin
                bit_cnt  <= '0;
                byte_idx <= nxt;
                if (nxt == total) begin
                  st   <= ENG_GAP;
                  cs_n <= 1'b1;
                  mosi <= 1'b0;
                end else if (nxt <= {1'b0, tx_n}) begin
                  tx_sh <= fifo_rdata;
                  mosi  <= fifo_rdata[7];
                end else begin
                  tx_sh <= '0;
                  mosi  <= 1'b0;
                end
              end else begin
                tx_sh <= {tx_sh[6:0], 1'b0};
                mosi  <= tx_sh[6];
              end
            end
          end
        end
        ENG_GAP: begin
          if (div_cnt == CW'(4*DIV-1)) begin
            st      <= ENG_IDLE;
            div_cnt <= '0;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  a_r2_mosi_hold_high_sck: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sck && $past(sck) && !$past(rst)) |-> $stable(mosi));
  a_r10_gap_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> busy);
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import spif_pkg::*;
#(
  parameter int DIV   = 2,
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    op_q, cnt_q;
  logic          busy, start, ptr_clr, d_wr, d_rd;
  logic [7:0]    fifo_bus_q, eng_rdata, eng_wdata;
  logic [PW-1:0] ptr, eng_ridx, eng_widx;
  logic          eng_wr;

  assign start   = wr_en && addr == OFS_CTRL && wdata[CTRL_GO_BIT] && !busy;
  assign ptr_clr = wr_en && addr == OFS_CTRL && wdata[CTRL_CLR_BIT];
  assign d_wr    = wr_en && addr == OFS_DATA && !busy;
  assign d_rd    = rd_en && addr == OFS_DATA;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= '0;
      cnt_q <= '0;
    end else if (wr_en && !busy) begin
      if (addr == OFS_OPCODE) op_q  <= wdata;
      if (addr == OFS_COUNTS) cnt_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        OFS_OPCODE: rdata <= op_q;
        OFS_COUNTS: rdata <= cnt_q;
        OFS_CTRL:   rdata <= {7'd0, busy};
        OFS_STAT:   rdata <= {busy, 7'd0};
        OFS_DATA:   rdata <= fifo_bus_q;
        OFS_PTR:    rdata <= 8'(ptr);
        default:    rdata <= '0;
      endcase
    end
  end

  spif_fifo #(.DEPTH(DEPTH), .W(8), .PW(PW)) u_fifo (
    .clk(clk), .rst(rst), .ptr_clr(ptr_clr),
    .bus_wr(d_wr), .bus_rd(d_rd), .bus_wdata(wdata), .bus_rdata(fifo_bus_q),
    .ptr(ptr), .eng_ridx(eng_ridx), .eng_rdata(eng_rdata),
    .eng_wr(eng_wr), .eng_widx(eng_widx), .eng_wdata(eng_wdata)
  );

  spif_shifter #(.DIV(DIV), .PW(PW)) u_shift (
    .clk(clk), .rst(rst), .start(start),
    .opcode(op_q), .tx_cnt(cnt_q[3:0]), .rx_cnt(cnt_q[7:4]), .busy(busy),
    .fifo_ridx(eng_ridx), .fifo_rdata(eng_rdata),
    .fifo_wr(eng_wr), .fifo_widx(eng_widx), .fifo_wdata(eng_wdata),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  a_r3_cs_implies_busy: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
  a_r8_opcode_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && addr == OFS_OPCODE) |=> $stable(op_q));
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && addr == OFS_DATA && !rd_en) |=> $stable(ptr));
endmodule

// File: tb/spi_flash_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_tb_top;
  localparam int DIV = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sck, cs_n, mosi, miso;

  int total = 0, bad = 0, prints = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  spi_flash_cmd_engine #(.DIV(DIV), .DEPTH(8)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model
  logic [7:0] cap_q[$];
  logic [7:0] sh = '0;
  int bitc = 0, slot = 0, tcount = 0;
  function automatic logic [7:0] resp(int t, int s);
    return 8'hA5 ^ {4'(t), 4'(s)};
  endfunction
  assign miso = cs_n ? 1'b0 : resp(tcount, slot)[7 - bitc];
  always @(posedge sck) if (!cs_n) begin
    sh = {sh[6:0], mosi};
    if (bitc == 7) begin cap_q.push_back(sh); bitc = 0; slot++; end
    else bitc++;
  end
  always @(posedge cs_n) begin tcount++; slot = 0; bitc = 0; end

  // cycle model of chip select
  int low_left = 0, busy_left = 0;
  logic [7:0] m_cnt = '0;
  always @(posedge clk) begin
    cyc++;
    if (rst) begin low_left = 0; busy_left = 0; m_cnt = '0; end
    else if (busy_left > 0) begin
      busy_left--;
      if (low_left > 0) low_left--;
    end else begin
      if (wr_en && addr == 4'h1) m_cnt = wdata;
      if (wr_en && addr == 4'h2 && wdata[0]) begin
        low_left  = 16 * DIV * (1 + m_cnt[3:0] + m_cnt[7:4]);
        busy_left = low_left + 4 * DIV;
      end
    end
  end
  always @(negedge clk) if (!rst) begin
    total++;
    if (cs_n !== (low_left == 0) || (cs_n && sck)) begin
      bad++;
      if (prints < 10) begin
        prints++;
        $display("FAIL R10 cycle %0d actual cs_n=%0b sck=%0b expected cs_n=%0b sck=0",
                 cyc, cs_n, sck, low_left == 0);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask
  task automatic wait_done();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(4'h2, v);
      if (!v[0]) return;
    end
    chk("R3 completion", 1, 0);
  endtask
  task automatic chk_cap(input string req, input logic [7:0] exp[$]);
    chk({req, " byte count"}, cap_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < cap_q.size(); i++)
      chk({req, " sent byte"}, cap_q[i], exp[i]);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ex[$];
    int t;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 cs_n", cs_n, 1); chk("R1 sck", sck, 0); chk("R1 mosi", mosi, 0);
    rd(4'h0, v); chk("R1 opcode reg", v, 0);
    rd(4'h1, v); chk("R1 count reg", v, 0);
    rd(4'h2, v); chk("R1 ctrl reg", v, 0);
    rd(4'h3, v); chk("R1 status reg", v, 0);
    rd(4'hD, v); chk("R1 pointer", v, 0);

    // R7 / R2: single command byte
    wr(4'h0, 8'h06); wr(4'h1, 8'h00);
    rd(4'h0, v); chk("R2 opcode readback", v, 8'h06);
    cap_q.delete();
    wr(4'h2, 8'h01);
    wait_done();
    ex = '{8'h06}; chk_cap("R7", ex);

    // R5 / R4: seven send bytes
    wr(4'h0, 8'h02); wr(4'h1, 8'h07); wr(4'h2, 8'h10);
    ex = '{8'h02, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE};
    for (int i = 1; i < 8; i++) wr(4'hC, ex[i]);
    rd(4'hD, v); chk("R4 pointer after 7 writes", v, 7);
    wr(4'h2, 8'h10);
    rd(4'hD, v); chk("R4 pointer clear", v, 0);
    cap_q.delete();
    wr(4'h2, 8'h01);
    rd(4'h3, v); chk("R3 status busy bit", v[7], 1);
    rd(4'h2, v); chk("R3 start bit running", v[0], 1);
    wait_done();
    rd(4'h3, v); chk("R3 status clear", v, 0);
    chk_cap("R5 R2", ex);

    // R6 / R8: send 3 reply 2, with writes during busy
    wr(4'h0, 8'h90); wr(4'h1, 8'h23); wr(4'h2, 8'h10);
    wr(4'hC, 8'h00); wr(4'hC, 8'h11); wr(4'hC, 8'h22);
    t = tcount;
    cap_q.delete();
    wr(4'h2, 8'h01);
    wr(4'h0, 8'h55); wr(4'h1, 8'hFF); wr(4'hC, 8'h77);
    rd(4'hD, v); chk("R8 pointer held while busy", v, 3);
    wr(4'h2, 8'h01);
    wait_done();
    rd(4'h0, v); chk("R8 opcode held", v, 8'h90);
    rd(4'h1, v); chk("R8 counts held", v, 8'h23);
    ex = '{8'h90, 8'h00, 8'h11, 8'h22, 8'h00, 8'h00}; chk_cap("R6 R8", ex);
    wr(4'h2, 8'h10);
    rd(4'hC, v); chk("R6 entry0 sent", v, 8'h00);
    rd(4'hC, v); chk("R6 entry1 sent", v, 8'h11);
    rd(4'hC, v); chk("R6 entry2 sent", v, 8'h22);
    rd(4'hC, v); chk("R6 reply0", v, resp(t, 4));
    rd(4'hC, v); chk("R6 reply1", v, resp(t, 5));

    // R6: reply only
    wr(4'h0, 8'h05); wr(4'h1, 8'h10);
    t = tcount;
    wr(4'h2, 8'h11);
    wait_done();
    wr(4'h2, 8'h10);
    rd(4'hC, v); chk("R6 reply-only byte", v, resp(t, 1));

    // R9: wrap
    wr(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) wr(4'hC, 8'(i));
    rd(4'hD, v); chk("R9 pointer wrap", v, 1);
    rd(4'hC, v); chk("R9 wrapped entry", v, 8'h01);

    repeat (20) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule